// File: doc/BRIEF.md
# Binary Keying Modulator

This block turns a serial stream of baseband bits into a digital carrier that is keyed by amplitude, by frequency or by phase. A phase accumulator sets the carrier frequency. The top bits of the accumulated phase address a quarter-wave sine table, and quadrant folding rebuilds the full period from that quarter. A latched data bit then decides what the output does. It can silence the carrier, swap the tuning word, or invert the carrier.

A transmission clock outside the block supplies a one-cycle strobe for each bit. On that strobe the block captures the data bit, the mode and both tuning words. Between strobes the controls stay frozen, so the waveform variant changes only at bit boundaries. The accumulator never restarts on a strobe. A frequency change is therefore phase-continuous.

Top module: `bkey_mod`

## Requirements
- R1: When `rst_n` is asserted (low), the output goes to zero at once. After reset, the phase is zero, the latched bit is 0, the latched mode is 00 and both latched tuning words are zero. The output then stays zero until the first strobe.
- R2: On a rising clock edge with `bit_stb` high, `data_bit`, `mode_sel`, `step_a` and `step_b` are captured. On every other edge these inputs have no effect on the output.
- R3: On every clock edge the phase register adds the selected tuning word, modulo 2^PHASE_W.
- R4: The sine value is built from the phase fields. The quadrant is the top 2 phase bits. The index `i` is the next LUT_AW bits. With Q = 2^LUT_AW, the table address is `i` in quadrants 0 and 2, and Q-1-i in quadrants 1 and 3. The magnitude for address k is floor(A*16*a*(4Q-a) / (5*(4Q)^2 - 4*a*(4Q-a))), where a = 2k+1 and A = 2^(SAMP_W-1)-1. The value is negated in quadrants 2 and 3.
- R5: Mode 00 (amplitude keying): a latched 1 outputs the sine and a latched 0 outputs exactly zero. The phase keeps advancing by `step_a` in both cases.
- R6: Mode 01 (frequency keying): a latched 1 advances the phase by `step_a` and a latched 0 advances it by `step_b`. The output is the sine, and the phase carries across every bit change without a jump.
- R7: Mode 10 (phase keying): a latched 1 outputs the sine and a latched 0 outputs its negation. The phase advances by `step_a`.
- R8: Mode 11 (plain carrier): the sine is output regardless of the latched bit, with the phase advancing by `step_a`. The sine is never zero.
- R9: `sample_out` is registered. It shows the value that R4 to R8 give for the phase and the latched controls held before the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Keying mode, captured on strobe (00 amplitude, 01 frequency, 10 phase, 11 carrier) |
| step_a | input | PHASE_W | Carrier tuning word, also the frequency-keying word for bit 1 |
| step_b | input | PHASE_W | Frequency-keying word for bit 0 |
| data_bit | input | 1 | Baseband bit, captured on strobe |
| bit_stb | input | 1 | One-cycle bit strobe from the transmission clock |
| sample_out | output | SAMP_W | Signed two's-complement output sample |

## Verification
Two events can land in the same clock edge: a bit strobe that swaps the keying variant, and the accumulator crossing a quadrant or wrap boundary. The bench provokes this on purpose. It uses a tuning word that makes one quadrant exactly 64 cycles long and strobes every 64 cycles, so each new bit lands on a quadrant edge. Odd tuning words are also used, which spread the strobes over arbitrary phases. An arithmetic model of the accumulator, the fold and the keying rules predicts every sample. The bench compares the design against that model on each cycle across all four modes and pseudo-random bit streams.

// File: rtl/bkey_pkg.sv
package bkey_pkg;
  typedef enum logic [1:0] {
    KEY_ASK = 2'b00,
    KEY_FSK = 2'b01,
    KEY_PSK = 2'b10,
    KEY_CAR = 2'b11
  } key_mode_e;
endpackage

// File: rtl/bkey_rst_sync.sv
module bkey_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/bkey_ctl_latch.sv
module bkey_ctl_latch
  import bkey_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stb,
  input  logic               bit_in,
  input  logic [1:0]         mode_in,
  input  logic [PHASE_W-1:0] step_a_in,
  input  logic [PHASE_W-1:0] step_b_in,
  output logic               bit_q,
  output key_mode_e          mode_q,
  output logic [PHASE_W-1:0] step_a_q,
  output logic [PHASE_W-1:0] step_b_q
);
  logic               bit_d;
  key_mode_e          mode_d;
  logic [PHASE_W-1:0] step_a_d;
  logic [PHASE_W-1:0] step_b_d;

  always_comb begin
    bit_d    = bit_q;
    mode_d   = mode_q;
    step_a_d = step_a_q;
    step_b_d = step_b_q;
    if (stb) begin
      bit_d    = bit_in;
      mode_d   = key_mode_e'(mode_in);
      step_a_d = step_a_in;
      step_b_d = step_b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= 1'b0;
      mode_q   <= KEY_ASK;
      step_a_q <= '0;
      step_b_q <= '0;
    end else begin
      bit_q    <= bit_d;
      mode_q   <= mode_d;
      step_a_q <= step_a_d;
      step_b_q <= step_b_d;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(bit_q) && $stable(mode_q) && $stable(step_a_q) && $stable(step_b_q)));
endmodule

// File: rtl/bkey_phase_acc.sv
module bkey_phase_acc
  import bkey_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int HI_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  key_mode_e          mode_q,
  input  logic               bit_q,
  input  logic [PHASE_W-1:0] step_a_q,
  input  logic [PHASE_W-1:0] step_b_q,
  output logic [HI_W-1:0]    phase_hi
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W-1:0] step_sel;

  always_comb begin
    step_sel = step_a_q;
    if (mode_q == KEY_FSK && !bit_q) step_sel = step_b_q;
    phase_d = phase_q + step_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_hi = phase_q[PHASE_W-1 -: HI_W];

  // R6
  fsk_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == KEY_FSK) |=> ((phase_q - $past(phase_q)) == $past(step_a_q) ||
                            (phase_q - $past(phase_q)) == $past(step_b_q)));
endmodule

// File: rtl/bkey_sine_fold.sv
module bkey_sine_fold #(
  parameter int LUT_AW = 6,
  parameter int SAMP_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LUT_AW+1:0]        phase_hi,
  output logic signed [SAMP_W-1:0] sine
);
  localparam int    QN    = 1 << LUT_AW;
  localparam int    MAG_W = SAMP_W - 1;
  localparam longint AMP  = (longint'(1) << MAG_W) - 1;

  function automatic logic [MAG_W-1:0] quarter_mag(input longint k);
    longint a, d, num, den;
    a   = 2 * k + 1;
    d   = 4 * longint'(QN);
    num = AMP * 16 * a * (d - a);
    den = 5 * d * d - 4 * a * (d - a);
    return MAG_W'(num / den);
  endfunction

  logic [MAG_W-1:0] tbl [QN];

  for (genvar k = 0; k < QN; k++) begin : g_tbl
    assign tbl[k] = quarter_mag(longint'(k));
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW-1:0] addr;
  logic signed [SAMP_W-1:0] pos;

  always_comb begin
    quad = phase_hi[LUT_AW+1 -: 2];
    idx  = phase_hi[LUT_AW-1:0];
    addr = quad[0] ? ~idx : idx;
    pos  = $signed({1'b0, tbl[addr]});
    sine = quad[1] ? -pos : pos;
  end

  // R4
  half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_hi[LUT_AW+1] |-> (sine > 0));
endmodule

// File: rtl/bkey_mod.sv
module bkey_mod
  import bkey_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 6,
  parameter int SAMP_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_sel,
  input  logic [PHASE_W-1:0]       step_a,
  input  logic [PHASE_W-1:0]       step_b,
  input  logic                     data_bit,
  input  logic                     bit_stb,
  output logic signed [SAMP_W-1:0] sample_out
);
  localparam int HI_W = LUT_AW + 2;

  logic               rst_s_n;
  logic               bit_q;
  key_mode_e          mode_q;
  logic [PHASE_W-1:0] step_a_q;
  logic [PHASE_W-1:0] step_b_q;
  logic [HI_W-1:0]    phase_hi;
  logic signed [SAMP_W-1:0] sine;
  logic signed [SAMP_W-1:0] sine_neg;
  logic signed [SAMP_W-1:0] sample_d;

  bkey_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  bkey_ctl_latch #(.PHASE_W(PHASE_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .stb       (bit_stb),
    .bit_in    (data_bit),
    .mode_in   (mode_sel),
    .step_a_in (step_a),
    .step_b_in (step_b),
    .bit_q     (bit_q),
    .mode_q    (mode_q),
    .step_a_q  (step_a_q),
    .step_b_q  (step_b_q)
  );

  bkey_phase_acc #(.PHASE_W(PHASE_W), .HI_W(HI_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mode_q   (mode_q),
    .bit_q    (bit_q),
    .step_a_q (step_a_q),
    .step_b_q (step_b_q),
    .phase_hi (phase_hi)
  );

  bkey_sine_fold #(.LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_fold (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .phase_hi (phase_hi),
    .sine     (sine)
  );

  always_comb begin
    sine_neg = -sine;
    case (mode_q)
      KEY_ASK: sample_d = bit_q ? sine : '0;
      KEY_FSK: sample_d = sine;
      KEY_PSK: sample_d = bit_q ? sine : sine_neg;
      default: sample_d = sine;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) sample_out <= '0;
    else          sample_out <= sample_d;
  end

  // R5
  ask_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == KEY_ASK && !bit_q) |=> (sample_out == '0));

  // R8
  car_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == KEY_CAR) |=> (sample_out != '0));

  // R7
  psk_sign_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == KEY_PSK && !bit_q) |=> (sample_out[SAMP_W-1] == !$past(phase_hi[HI_W-1])));
endmodule

// File: tb/bkey_mod_bench.sv
`timescale 1ns/1ps
module bkey_mod_bench;
  localparam int PW = 16;
  localparam int LA = 6;
  localparam int SW = 12;
  localparam int QN = 1 << LA;
  localparam longint AMP = 2047;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           mode_sel = 2'b00;
  logic [PW-1:0]        step_a = '0;
  logic [PW-1:0]        step_b = '0;
  logic                 data_bit = 1'b0;
  logic                 bit_stb = 1'b0;
  logic signed [SW-1:0] sample_out;

  int checks = 0;
  int errors = 0;

  logic [PW-1:0] m_ph;
  logic [1:0]    m_mode;
  logic          m_bit;
  logic [PW-1:0] m_sa, m_sb;
  int            m_exp;
  logic [15:0]   lf = 16'hACE1;

  always #2.5 clk = ~clk;

  bkey_mod #(.PHASE_W(PW), .LUT_AW(LA), .SAMP_W(SW)) u_bkey_mod (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .step_a(step_a), .step_b(step_b),
    .data_bit(data_bit), .bit_stb(bit_stb), .sample_out(sample_out)
  );

  // R4 magnitude formula
  function automatic int mag_m(input int k);
    longint a, d;
    a = 2 * longint'(k) + 1;
    d = 4 * longint'(QN);
    return int'((AMP * 16 * a * (d - a)) / (5 * d * d - 4 * a * (d - a)));
  endfunction

  function automatic int sine_m(input logic [PW-1:0] ph);
    int q, i, s;
    q = int'(ph[PW-1 -: 2]);
    i = int'(ph[PW-3 -: LA]);
    s = mag_m((q % 2 == 1) ? (QN - 1 - i) : i);
    return (q >= 2) ? -s : s;
  endfunction

  function automatic int exp_m(input logic [PW-1:0] ph, input logic [1:0] md, input logic b);
    int s;
    s = sine_m(ph);
    case (md)
      2'b00:   return b ? s : 0;
      2'b10:   return b ? s : -s;
      default: return s;
    endcase
  endfunction

  task automatic model_reset();
    m_ph = '0; m_mode = 2'b00; m_bit = 1'b0; m_sa = '0; m_sb = '0; m_exp = 0;
  endtask

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: sample_out=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: check previous output, drive inputs, step the model at the edge
  task automatic cyc(input logic stb, input logic b, input logic [1:0] md,
                     input logic [PW-1:0] sa, input logic [PW-1:0] sb, input string tag);
    @(negedge clk);
    check(int'(sample_out), m_exp, tag);
    bit_stb = stb; data_bit = b; mode_sel = md; step_a = sa; step_b = sb;
    @(posedge clk);
    #1;
    m_exp = exp_m(m_ph, m_mode, m_bit);
    m_ph  = m_ph + ((m_mode == 2'b01 && !m_bit) ? m_sb : m_sa);
    if (stb) begin
      m_bit = b; m_mode = md; m_sa = sa; m_sb = sb;
    end
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic keyed_run(input logic [1:0] md, input logic [PW-1:0] sa,
                           input logic [PW-1:0] sb, input int period, input int nbits);
    for (int n = 0; n < nbits; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      for (int c = 0; c < period; c++)
        cyc(c == 0, lf[0], md, sa, sb, mode_tag(md));
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(int'(sample_out), 0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check(int'(sample_out), 0, "R1 after release");

    // R2: inputs toggled without strobe are ignored
    for (int n = 0; n < 24; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(1'b0, lf[1], lf[3:2], lf, ~lf, "R2");
    end

    // R4/R3/R9: carrier sweep through every table position
    cyc(1'b1, 1'b0, 2'b11, 16'd256, 16'd0, "R8");
    for (int n = 0; n < 300; n++) cyc(1'b0, 1'b1, 2'b00, 16'd0, 16'd0, "R4 R9");

    // R2: mid-run noise without strobe keeps the carrier undisturbed
    for (int n = 0; n < 40; n++) cyc(1'b0, n[0], 2'b01, 16'h1234, 16'h4321, "R2 R3");

    // strobes aligned with quadrant edges (64 cycles per quadrant at step 256)
    for (int m = 0; m < 4; m++) keyed_run(2'(m), 16'd256, 16'd1024, 64, 16);
    // strobes at arbitrary phase with odd tuning words
    for (int m = 0; m < 4; m++) keyed_run(2'(m), 16'd301, 16'd1187, 37, 20);

    // R3: wrap with a large tuning word
    cyc(1'b1, 1'b1, 2'b11, 16'hF123, 16'd0, "R3");
    for (int n = 0; n < 100; n++) cyc(1'b0, 1'b0, 2'b11, 16'hF123, 16'd0, "R3");

    // R1: asynchronous reset in mid-stream
    @(negedge clk);
    check(int'(sample_out), m_exp, "R3");
    rst_n = 1'b0;
    #1;
    check(int'(sample_out), 0, "R1 async");
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int n = 0; n < 10; n++) cyc(1'b0, 1'b1, 2'b11, 16'd999, 16'd0, "R1 held zero");
    keyed_run(2'b10, 16'd512, 16'd0, 32, 8);
    @(negedge clk);
    check(int'(sample_out), m_exp, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule